// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block owns the refresh duty of an asynchronous DRAM. Coming out of reset it holds both strobes inactive for a long settling pause and then runs a fixed train of CAS-before-RAS cycles to initialise the array. Until that train is over the block owns the strobes outright and `initDone` stays low, so the access controller keeps off the bus. Once `initDone` is high, a free-running interval timer adds one owed refresh per period. Each owed refresh is serviced through a request/grant handshake. While granted, the block drives RAS and CAS itself.

The access controller raises `refGrant` while `refReq` is high and the bus is idle. It takes the bus back when `refReq` falls. Periodic refreshes are CAS-before-RAS cycles by default. With `useRasOnly` high they become row-address refreshes instead: CAS stays inactive and the row comes from an internal wrapping row counter. Raising `selfReq` asks for self-refresh. The block enters self-refresh through the same handshake and holds RAS low for at least the minimum self-refresh time, however early `selfReq` drops, so the strobe never rises inside the forbidden mode-transition window. On exit it enforces a long precharge before giving the bus back.

All durations are parameters counted in clock cycles.

Top module: `dram_refresh_seq`

## Requirements
- R1: During reset and after it, `rasN` and `casN` are high, `initDone` and `refReq` are low and `busOwn` is high. The first fall of `casN` comes exactly PAUSE_CYC cycles after reset is released.
- R2: Before `initDone` rises, exactly INIT_CYCLES CAS-before-RAS cycles are issued with `refReq` held low. `initDone` rises PAUSE_CYC + INIT_CYCLES*(CAS_SETUP_CYC+RAS_LOW_CYC+PRECH_CYC) cycles after reset release.
- R3: In every CAS-before-RAS cycle, `casN` is low for exactly CAS_SETUP_CYC cycles before `rasN` falls. `rasN` then stays low for RAS_LOW_CYC cycles with `casN` still low, and both rise in the same cycle. Every fall of `rasN` follows at least PRECH_CYC cycles of `rasN` high.
- R4: After `initDone`, `owedCount` rises by one every INTERVAL_CYC cycles. The first rise comes INTERVAL_CYC cycles after `initDone`. In idle, `refReq` rises one cycle after `owedCount` becomes non-zero. The schedule is not shifted by when grants arrive.
- R5: The first strobe of a refresh (`casN`, or `rasN` in row mode) falls in the cycle after `refGrant` is sampled high. `refReq` stays high until the precharge ends and then falls. Any strobe low implies `busOwn` high.
- R6: Withheld grants accumulate in `owedCount`, which saturates at 2^OWED_W-1 and changes by at most one per cycle outside self-refresh. Once grants resume, exactly the owed number of refreshes run back to back and the count returns to zero.
- R7: With `useRasOnly` high at grant time, the refresh holds `casN` high and drives `rasN` low for RAS_LOW_CYC cycles with `addrDrive` high. `rowAddr` starts at 0 and advances by one per row refresh, wrapping modulo 2^ROW_W.
- R8: When `selfReq` is high, the block requests the bus. On grant it lowers `casN` for CAS_SETUP_CYC cycles and then `rasN`, with `selfActive` high and both strobes low while in self-refresh.
- R9: In self-refresh, `rasN` stays low for at least SELF_MIN_CYC cycles, exactly SELF_MIN_CYC when `selfReq` is already low, and for as long as `selfReq` stays high.
- R10: On leaving self-refresh, `refReq` stays high for exactly SELF_EXIT_CYC cycles after `rasN` rises. `owedCount` is zero throughout self-refresh and exit. The interval restarts, so the next `refReq` rises SELF_EXIT_CYC+INTERVAL_CYC+1 cycles after `rasN` rose.
- R11: `addrDrive` is high exactly when `rasN` is low and `casN` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| refGrant | input | 1 | Access controller hands the strobes to this block |
| selfReq | input | 1 | Level request to be in self-refresh |
| useRasOnly | input | 1 | 1: periodic refreshes are row-address refreshes |
| refReq | output | 1 | Request for the DRAM bus, held until the refresh or self-refresh is over |
| busOwn | output | 1 | This block is driving the strobes |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe (both byte lanes), active low |
| addrDrive | output | 1 | `rowAddr` must be put on the address pins |
| rowAddr | output | ROW_W | Row for row-address refresh |
| initDone | output | 1 | Pause and init cycles are complete |
| selfActive | output | 1 | Device is held in self-refresh |
| owedCount | output | OWED_W | Refreshes owed and not yet started |

## Verification
Every cycle, the bound checker enforces the strobe ordering rules: CAS leads RAS in CBR cycles, CAS never rises alone, row refreshes keep CAS high with the address driven, and both strobes are low in self-refresh. It also checks that no request is made before initialisation, that no strobe is low without bus ownership, that the owed count moves by at most one outside self-refresh, and that the self-refresh RAS-low time never falls short of the minimum. The exact pause and init timing, the interval phase, saturation followed by back-to-back catch-up, the full wrap of the row counter, and the exit precharge and interval restart after self-refresh all depend on long scenarios, so only the bench's timed sweeps can show them.

// File: rtl/drs_pkg.sv
package drs_pkg;

  typedef enum logic [3:0] {
    ST_PAUSE,
    ST_IDLE,
    ST_REQ,
    ST_CBR_CAS,
    ST_CBR_RAS,
    ST_RO_RAS,
    ST_PRECH,
    ST_SELF_CAS,
    ST_SELF_HOLD,
    ST_SELF_EXIT
  } seqState_t;

  typedef enum logic [2:0] {
    DUR_CAS,
    DUR_RAS,
    DUR_PRE,
    DUR_SELF,
    DUR_EXIT
  } durSel_t;

  // strobes from control to datapath
  typedef struct packed {
    logic    tmrLoad;
    durSel_t durSel;
    logic    initStep;
    logic    initFinish;
    logic    rowStep;
    logic    owedDec;
    logic    owedClr;
    logic    intvHold;
  } ctrlStrobe_t;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/drs_dpath.sv
module drs_dpath
  import drs_pkg::*;
#(
  parameter int PAUSE_CYC     = 25000,
  parameter int INIT_CYCLES   = 8,
  parameter int CAS_SETUP_CYC = 1,
  parameter int RAS_LOW_CYC   = 7,
  parameter int PRECH_CYC     = 4,
  parameter int INTERVAL_CYC  = 1950,
  parameter int SELF_MIN_CYC  = 12500,
  parameter int SELF_EXIT_CYC = 12,
  parameter int ROW_W         = 10,
  parameter int OWED_W        = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlStrobe_t       strb,
  output logic              tmrZero,
  output logic              initReached,
  output logic              initDone,
  output logic              owedPending,
  output logic [OWED_W-1:0] owedCount,
  output logic [ROW_W-1:0]  rowAddr
);

  localparam int TMR_MAX = imax(imax(imax(PAUSE_CYC, SELF_MIN_CYC),
                                     imax(CAS_SETUP_CYC, RAS_LOW_CYC)),
                                imax(PRECH_CYC, SELF_EXIT_CYC));
  localparam int TMR_W  = $clog2(TMR_MAX + 1);
  localparam int INIT_W = $clog2(INIT_CYCLES + 1);
  localparam int INTV_W = $clog2(INTERVAL_CYC + 1);
  localparam logic [OWED_W-1:0] OWED_MAX = '1;

  // phase timer shared by every timed state
  logic [TMR_W-1:0] tmr;
  logic [TMR_W-1:0] durVal;

  always_comb begin
    case (strb.durSel)
      DUR_CAS:  durVal = TMR_W'(CAS_SETUP_CYC - 1);
      DUR_RAS:  durVal = TMR_W'(RAS_LOW_CYC - 1);
      DUR_PRE:  durVal = TMR_W'(PRECH_CYC - 1);
      DUR_SELF: durVal = TMR_W'(SELF_MIN_CYC - 1);
      DUR_EXIT: durVal = TMR_W'(SELF_EXIT_CYC - 1);
      default:  durVal = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              tmr <= TMR_W'(PAUSE_CYC - 1);
    else if (strb.tmrLoad)   tmr <= durVal;
    else if (tmr != '0)      tmr <= tmr - 1'b1;
  end

  assign tmrZero = (tmr == '0);

  // init cycle counting
  logic [INIT_W-1:0] initCnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      initCnt  <= '0;
      initDone <= 1'b0;
    end else begin
      if (strb.initStep && !initDone) initCnt <= initCnt + 1'b1;
      if (strb.initFinish)            initDone <= 1'b1;
    end
  end

  assign initReached = (initCnt == INIT_W'(INIT_CYCLES));

  // free-running refresh interval
  logic [INTV_W-1:0] intvCnt;
  logic              intvTick;

  assign intvTick = initDone && !strb.intvHold && (intvCnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      intvCnt <= INTV_W'(INTERVAL_CYC - 1);
    else if (!initDone || strb.intvHold || intvCnt == '0)
      intvCnt <= INTV_W'(INTERVAL_CYC - 1);
    else
      intvCnt <= intvCnt - 1'b1;
  end

  // owed refresh count, saturating
  logic owedInc;
  logic owedDecOk;

  assign owedInc   = intvTick && (owedCount != OWED_MAX);
  assign owedDecOk = strb.owedDec && (owedCount != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            owedCount <= '0;
    else if (strb.owedClr) owedCount <= '0;
    else                   owedCount <= owedCount + {{(OWED_W-1){1'b0}}, owedInc}
                                                   - {{(OWED_W-1){1'b0}}, owedDecOk};
  end

  assign owedPending = (owedCount != '0);

  // row counter for row-address refresh
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            rowAddr <= '0;
    else if (strb.rowStep) rowAddr <= rowAddr + 1'b1;
  end

endmodule

// File: rtl/drs_ctrl.sv
module drs_ctrl
  import drs_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        refGrant,
  input  logic        selfReq,
  input  logic        useRasOnly,
  input  logic        tmrZero,
  input  logic        initReached,
  input  logic        initDone,
  input  logic        owedPending,
  output ctrlStrobe_t strb,
  output logic        rasN,
  output logic        casN,
  output logic        refReq,
  output logic        busOwn,
  output logic        addrDrive,
  output logic        selfActive
);

  seqState_t st;
  seqState_t stNext;

  always_comb begin
    stNext = st;
    strb   = '0;
    case (st)
      ST_PAUSE: begin
        if (tmrZero) begin
          stNext       = ST_CBR_CAS;
          strb.tmrLoad = 1'b1;
          strb.durSel  = DUR_CAS;
        end
      end
      ST_IDLE: begin
        if (selfReq || owedPending) stNext = ST_REQ;
      end
      ST_REQ: begin
        if (refGrant && selfReq) begin
          stNext       = ST_SELF_CAS;
          strb.tmrLoad = 1'b1;
          strb.durSel  = DUR_CAS;
        end else if (refGrant && owedPending) begin
          strb.owedDec = 1'b1;
          strb.tmrLoad = 1'b1;
          if (useRasOnly) begin
            stNext      = ST_RO_RAS;
            strb.durSel = DUR_RAS;
          end else begin
            stNext      = ST_CBR_CAS;
            strb.durSel = DUR_CAS;
          end
        end else if (!selfReq && !owedPending) begin
          stNext = ST_IDLE;
        end
      end
      ST_CBR_CAS: begin
        if (tmrZero) begin
          stNext       = ST_CBR_RAS;
          strb.tmrLoad = 1'b1;
          strb.durSel  = DUR_RAS;
        end
      end
      ST_CBR_RAS: begin
        if (tmrZero) begin
          stNext        = ST_PRECH;
          strb.tmrLoad  = 1'b1;
          strb.durSel   = DUR_PRE;
          strb.initStep = !initDone;
        end
      end
      ST_RO_RAS: begin
        if (tmrZero) begin
          stNext       = ST_PRECH;
          strb.tmrLoad = 1'b1;
          strb.durSel  = DUR_PRE;
          strb.rowStep = 1'b1;
        end
      end
      ST_PRECH: begin
        if (tmrZero) begin
          if (initDone) begin
            stNext = ST_IDLE;
          end else if (initReached) begin
            stNext          = ST_IDLE;
            strb.initFinish = 1'b1;
          end else begin
            stNext       = ST_CBR_CAS;
            strb.tmrLoad = 1'b1;
            strb.durSel  = DUR_CAS;
          end
        end
      end
      ST_SELF_CAS: begin
        strb.intvHold = 1'b1;
        strb.owedClr  = 1'b1;
        if (tmrZero) begin
          stNext       = ST_SELF_HOLD;
          strb.tmrLoad = 1'b1;
          strb.durSel  = DUR_SELF;
        end
      end
      ST_SELF_HOLD: begin
        strb.intvHold = 1'b1;
        strb.owedClr  = 1'b1;
        // minimum hold enforced by the timer, whatever selfReq does
        if (tmrZero && !selfReq) begin
          stNext       = ST_SELF_EXIT;
          strb.tmrLoad = 1'b1;
          strb.durSel  = DUR_EXIT;
        end
      end
      ST_SELF_EXIT: begin
        strb.intvHold = 1'b1;
        strb.owedClr  = 1'b1;
        if (tmrZero) stNext = ST_IDLE;
      end
      default: stNext = ST_IDLE;
    endcase
  end

  // strobe outputs registered from the next-state decode
  logic rasLowNext, casLowNext, postInit;

  assign rasLowNext = (stNext == ST_CBR_RAS) || (stNext == ST_RO_RAS) ||
                      (stNext == ST_SELF_HOLD);
  assign casLowNext = (stNext == ST_CBR_CAS) || (stNext == ST_CBR_RAS) ||
                      (stNext == ST_SELF_CAS) || (stNext == ST_SELF_HOLD);
  assign postInit   = initDone || strb.initFinish;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_PAUSE;
      rasN       <= 1'b1;
      casN       <= 1'b1;
      refReq     <= 1'b0;
      busOwn     <= 1'b1;
      addrDrive  <= 1'b0;
      selfActive <= 1'b0;
    end else begin
      st         <= stNext;
      rasN       <= !rasLowNext;
      casN       <= !casLowNext;
      refReq     <= postInit && (stNext != ST_IDLE) && (stNext != ST_PAUSE);
      busOwn     <= (stNext != ST_IDLE) && (stNext != ST_REQ);
      addrDrive  <= (stNext == ST_RO_RAS);
      selfActive <= (stNext == ST_SELF_HOLD);
    end
  end

endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
  import drs_pkg::*;
#(
  parameter int PAUSE_CYC     = 25000,
  parameter int INIT_CYCLES   = 8,
  parameter int CAS_SETUP_CYC = 1,
  parameter int RAS_LOW_CYC   = 7,
  parameter int PRECH_CYC     = 4,
  parameter int INTERVAL_CYC  = 1950,
  parameter int SELF_MIN_CYC  = 12500,
  parameter int SELF_EXIT_CYC = 12,
  parameter int ROW_W         = 10,
  parameter int OWED_W        = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              refGrant,
  input  logic              selfReq,
  input  logic              useRasOnly,
  output logic              refReq,
  output logic              busOwn,
  output logic              rasN,
  output logic              casN,
  output logic              addrDrive,
  output logic [ROW_W-1:0]  rowAddr,
  output logic              initDone,
  output logic              selfActive,
  output logic [OWED_W-1:0] owedCount
);

  ctrlStrobe_t strb;
  logic tmrZero, initReached, owedPending;

  drs_ctrl uCtrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .refGrant    (refGrant),
    .selfReq     (selfReq),
    .useRasOnly  (useRasOnly),
    .tmrZero     (tmrZero),
    .initReached (initReached),
    .initDone    (initDone),
    .owedPending (owedPending),
    .strb        (strb),
    .rasN        (rasN),
    .casN        (casN),
    .refReq      (refReq),
    .busOwn      (busOwn),
    .addrDrive   (addrDrive),
    .selfActive  (selfActive)
  );

  drs_dpath #(
    .PAUSE_CYC     (PAUSE_CYC),
    .INIT_CYCLES   (INIT_CYCLES),
    .CAS_SETUP_CYC (CAS_SETUP_CYC),
    .RAS_LOW_CYC   (RAS_LOW_CYC),
    .PRECH_CYC     (PRECH_CYC),
    .INTERVAL_CYC  (INTERVAL_CYC),
    .SELF_MIN_CYC  (SELF_MIN_CYC),
    .SELF_EXIT_CYC (SELF_EXIT_CYC),
    .ROW_W         (ROW_W),
    .OWED_W        (OWED_W)
  ) uDpath (
    .clk         (clk),
    .rst_n       (rst_n),
    .strb        (strb),
    .tmrZero     (tmrZero),
    .initReached (initReached),
    .initDone    (initDone),
    .owedPending (owedPending),
    .owedCount   (owedCount),
    .rowAddr     (rowAddr)
  );

endmodule

// File: rtl/drs_checker.sv
module drs_checker #(
  parameter int SELF_MIN_CYC = 12500,
  parameter int OWED_W       = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rasN,
  input logic              casN,
  input logic              refReq,
  input logic              busOwn,
  input logic              addrDrive,
  input logic              initDone,
  input logic              selfActive,
  input logic [OWED_W-1:0] owedCount
);

  localparam int LOW_W = $clog2(SELF_MIN_CYC + 2);
  localparam logic [LOW_W-1:0] LOW_SAT = '1;

  // consecutive sampled cycles with the row strobe low
  logic [LOW_W-1:0] lowCnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              lowCnt <= '0;
    else if (rasN)           lowCnt <= '0;
    else if (lowCnt != LOW_SAT) lowCnt <= lowCnt + 1'b1;
  end

  a_r3_cas_leads_ras: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rasN) && !addrDrive |-> $past(!casN));

  a_r3_cas_rises_with_ras: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(casN) |-> $rose(rasN));

  a_r7_row_keeps_cas_high: assert property (@(posedge clk) disable iff (!rst_n)
    addrDrive |-> casN && !rasN);

  a_r2_no_request_in_init: assert property (@(posedge clk) disable iff (!rst_n)
    !initDone |-> !refReq);

  a_r5_strobes_need_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (!rasN || !casN) |-> busOwn);

  a_r6_owed_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    !selfActive |-> (owedCount == $past(owedCount)) ||
                    (owedCount == $past(owedCount) + 1'b1) ||
                    (owedCount == $past(owedCount) - 1'b1));

  a_r8_self_strobes_low: assert property (@(posedge clk) disable iff (!rst_n)
    selfActive |-> !rasN && !casN);

  a_r10_no_owed_in_self: assert property (@(posedge clk) disable iff (!rst_n)
    selfActive |-> owedCount == '0);

  a_r9_self_min_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rasN) && $past(selfActive) |-> lowCnt >= LOW_W'(SELF_MIN_CYC));

endmodule

bind dram_refresh_seq drs_checker #(
  .SELF_MIN_CYC (SELF_MIN_CYC),
  .OWED_W       (OWED_W)
) uChk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rasN       (rasN),
  .casN       (casN),
  .refReq     (refReq),
  .busOwn     (busOwn),
  .addrDrive  (addrDrive),
  .initDone   (initDone),
  .selfActive (selfActive),
  .owedCount  (owedCount)
);

// File: tb/dram_refresh_seq_test.sv
module dram_refresh_seq_test;

  localparam int P  = 20;   // pause
  localparam int N  = 8;    // init cycles
  localparam int C  = 2;    // CAS setup
  localparam int R  = 3;    // RAS low
  localparam int Q  = 2;    // precharge
  localparam int I  = 100;  // interval
  localparam int S  = 10;   // self minimum
  localparam int X  = 3;    // self exit precharge
  localparam int RW = 4;
  localparam int OW = 3;
  localparam int OMAX = (1 << OW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic grantEn = 1'b0;
  logic selfReq = 1'b0;
  logic useRasOnly = 1'b0;
  logic refGrant;
  logic refReq, busOwn, rasN, casN, addrDrive, initDone, selfActive;
  logic [RW-1:0] rowAddr;
  logic [OW-1:0] owedCount;

  assign refGrant = grantEn && refReq;

  always #4 clk = ~clk;

  dram_refresh_seq #(
    .PAUSE_CYC(P), .INIT_CYCLES(N), .CAS_SETUP_CYC(C), .RAS_LOW_CYC(R),
    .PRECH_CYC(Q), .INTERVAL_CYC(I), .SELF_MIN_CYC(S), .SELF_EXIT_CYC(X),
    .ROW_W(RW), .OWED_W(OW)
  ) uut (
    .clk(clk), .rst_n(rst_n), .refGrant(refGrant), .selfReq(selfReq),
    .useRasOnly(useRasOnly), .refReq(refReq), .busOwn(busOwn), .rasN(rasN),
    .casN(casN), .addrDrive(addrDrive), .rowAddr(rowAddr), .initDone(initDone),
    .selfActive(selfActive), .owedCount(owedCount)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  // strobe monitor, samples at the falling edge
  logic pRas = 1'b1, pCas = 1'b1, pSelf = 1'b0;
  int casRun = 0, rasLowRun = 0, rasHighRun = 0;
  int rasFalls = 0, roCount = 0, lastLow = 0;
  bit reqBeforeInit = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!initDone && refReq) reqBeforeInit = 1'b1;
      // R11: address drive matches row-only strobe pattern
      check(addrDrive == (!rasN && casN), "R11 addrDrive", addrDrive, !rasN && casN);
      if (pRas && !rasN) begin
        rasFalls++;
        check(rasHighRun >= Q, "R3 precharge before RAS fall", rasHighRun, Q);
        if (!casN) begin
          check(casRun == C, "R3 CAS lead", casRun, C);
        end else begin
          check(addrDrive && pCas, "R7 row refresh keeps CAS high", addrDrive, 1);
          check(rowAddr == RW'(roCount), "R7 row address", rowAddr, roCount % (1 << RW));
          roCount++;
        end
      end
      if (!pRas && rasN) begin
        lastLow = rasLowRun;
        check(casN, "R3 CAS rises with RAS", casN, 1);
        if (pSelf) check(rasLowRun >= S, "R9 self RAS low minimum", rasLowRun, S);
        else       check(rasLowRun == R, "R3 RAS low width", rasLowRun, R);
      end
      casRun     = casN ? 0 : (pCas ? 1 : casRun + 1);
      rasLowRun  = rasN ? 0 : (pRas ? 1 : rasLowRun + 1);
      rasHighRun = !rasN ? 0 : (!pRas ? 1 : rasHighRun + 1);
      pRas = rasN; pCas = casN; pSelf = selfActive;
    end
  end

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  int initT, t0, base, riseT;

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    check(rasN && casN, "R1 strobes high in reset", {rasN, casN}, 3);
    check(!initDone && !refReq, "R1 no init/no request in reset", {initDone, refReq}, 0);
    check(busOwn, "R1 busOwn in reset", busOwn, 1);
    rst_n = 1'b1;
    grantEn = 1'b1;

    while (casN) @(negedge clk);
    check(cyc == P, "R1 pause length", cyc, P);

    while (!initDone) @(negedge clk);
    initT = cyc;
    check(cyc == P + N * (C + R + Q), "R2 initDone time", cyc, P + N * (C + R + Q));
    check(rasFalls == N, "R2 init cycle count", rasFalls, N);
    check(!reqBeforeInit, "R2 no request during init", reqBeforeInit, 0);

    // R4/R5: periodic refresh timing with immediate grant
    while (!refReq) @(negedge clk);
    check(cyc == initT + I + 1, "R4 first request", cyc, initT + I + 1);
    waitCyc(1);
    check(!casN && busOwn, "R5 CAS falls after grant", casN, 0);
    while (refReq) @(negedge clk);
    check(cyc == initT + I + 2 + C + R + Q, "R5 request release", cyc, initT + I + 2 + C + R + Q);
    check(!busOwn, "R5 bus released", busOwn, 0);
    while (!refReq) @(negedge clk);
    check(cyc == initT + 2 * I + 1, "R4 steady interval", cyc, initT + 2 * I + 1);
    while (refReq) @(negedge clk);

    // R6: withheld grants, accumulation and saturation
    grantEn = 1'b0;
    for (int m = 3; m <= 11; m++) begin
      while (cyc < initT + m * I) @(negedge clk);
      check(owedCount == OW'((m - 2 > OMAX) ? OMAX : m - 2), "R6 owed accumulate/saturate",
            owedCount, (m - 2 > OMAX) ? OMAX : m - 2);
    end
    waitCyc(1);
    base = rasFalls;
    grantEn = 1'b1;
    while (owedCount != 0 || refReq) @(negedge clk);
    check(rasFalls - base == OMAX, "R6 catch-up count", rasFalls - base, OMAX);
    check(cyc < initT + 12 * I, "R6 catch-up before next tick", cyc, initT + 12 * I);

    // R7: row-address refresh sweep past a full wrap
    useRasOnly = 1'b1;
    while (roCount < (1 << RW) + 2 || refReq) @(negedge clk);
    check(roCount == (1 << RW) + 2, "R7 row refresh count", roCount, (1 << RW) + 2);
    useRasOnly = 1'b0;

    // R8..R10: self-refresh with early release
    selfReq = 1'b1;
    while (!selfActive) @(negedge clk);
    check(refReq && !casN && !rasN, "R8 self entry strobes", {refReq, casN, rasN}, 4);
    waitCyc(2);
    selfReq = 1'b0;
    while (!rasN) @(negedge clk);
    riseT = cyc;
    check(!selfActive && refReq, "R10 exit holds request", refReq, 1);
    check(owedCount == 0, "R10 owed cleared", owedCount, 0);
    waitCyc(1);
    check(lastLow == S, "R9 self low exact minimum", lastLow, S);
    while (refReq) @(negedge clk);
    check(cyc == riseT + X, "R10 exit precharge", cyc, riseT + X);
    while (!refReq) @(negedge clk);
    check(cyc == riseT + X + I + 1, "R10 interval restart", cyc, riseT + X + I + 1);
    while (refReq) @(negedge clk);

    // R9: self-refresh held by selfReq beyond minimum
    selfReq = 1'b1;
    while (!selfActive) @(negedge clk);
    waitCyc(S + 5);
    check(selfActive && !rasN, "R9 held while selfReq high", selfActive, 1);
    selfReq = 1'b0;
    while (!rasN) @(negedge clk);
    waitCyc(1);
    check(lastLow >= S + 5, "R9 long self low", lastLow, S + 5);
    while (refReq) @(negedge clk);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule